// File: doc/BRIEF.md
# Accumulator ALU with Per-Operation Flag Update Masks

This block is the arithmetic and logic stage of a small 8-bit processor core. Each cycle it can accept one operation: an operation code, two operands and the present flag byte. One clock later it returns a result, a new flag byte and a write enable for that result. Operand fetch, register file access and instruction sequencing all take place outside the block. The caller feeds the accumulator (or HL for the wide add) on `opa`. It feeds the second operand on `opb`.

Each operation writes only its own subset of the four flags: zero (Z), subtract (N), half-carry (H) and carry (C). Every flag outside that subset is copied from `flags_in`. This lets the core keep one flag register and feed it straight back. The operations are the eight accumulator binary operations, byte increment and decrement, a 16-bit add into HL, four accumulator rotates, decimal adjust, accumulator complement, set-carry and complement-carry. Codes that are not assigned to an operation are harmless no-ops.

Operation codes on `op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 wide add, 11 rotate left circular, 12 rotate right circular, 13 rotate left through carry, 14 rotate right through carry, 15 decimal adjust, 16 complement, 17 set carry, 18 complement carry. Codes 19 to 31 are unassigned.

Top module: `flagmask_alu`

## Requirements
- R1: Outputs are registered. When `in_valid` is high at a rising edge, `result`, `flags_out` and `res_we` take that operation's values and `out_valid` goes high. When `in_valid` is low, `out_valid` goes low and the other outputs hold. Reset clears every output to zero.
- R2: The flag byte is laid out as Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 of `flags_out` always read zero, whatever `flags_in` carries there.
- R3: Codes 0 to 3 compute `opa[7:0]` plus or minus `opb[7:0]`. Codes 1 and 3 also add or subtract the incoming C. All four flags are written: Z is set when the byte result is zero, N is set for subtraction, H is the carry or borrow out of bit 3, and C is the carry or borrow out of bit 7. `res_we` is 1 and `result[15:8]` is 0.
- R4: AND writes Z from the result, clears N and C, and sets H. XOR and OR write Z and clear N, H and C.
- R5: Compare sets all four flags exactly as subtract would. It gives `res_we` = 0 and `result` = 0.
- R6: Increment and decrement act on `opa[7:0]`. They write Z, N (0 for increment, 1 for decrement) and H (out of bit 3), and they keep C from `flags_in`.
- R7: The wide add returns the 16-bit sum `opa + opb`. It keeps Z, clears N, and takes H from the carry out of bit 11 and C from the carry out of bit 15.
- R8: The four rotates act on `opa[7:0]`. C receives the bit shifted out. The through-carry forms shift the old C in. N and H are cleared, and Z is always cleared, even for a zero result.
- R9: Decimal adjust corrects `opa[7:0]` after a BCD add or subtract, using the incoming N, H and C. It writes Z, H (cleared) and C, and keeps N.
- R10: Complement returns the bitwise inverse of `opa[7:0]`. It sets N and H and keeps Z and C.
- R11: Set-carry sets C. Complement-carry inverts C. Both clear N and H, keep Z, and give `res_we` = 0 and `result` = 0.
- R12: An unassigned code (19 to 31) keeps every flag, and gives `res_we` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| opa | input | 16 | Accumulator in bits 7..0, or HL for the wide add |
| opb | input | 16 | Second operand, bits 7..0 for byte operations |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | The outputs hold a fresh operation |
| result | output | 16 | Operation result |
| flags_out | output | 8 | New flag byte |
| res_we | output | 1 | The result must be written back |

## Verification
The block keeps only its output register, so any fault shows up at the ports in the cycle right after the operation is accepted. A flag taken from the wrong place is one example: a raw flag where the old value should have been kept, or the reverse. A wrong write enable is another, and so is a hold that fails on an idle cycle. The most telling stimuli are those that make kept and computed flags differ. Examples are increment with C set, the wide add with Z set, rotates of zero, and compare against equal operands. These are compared each cycle against a behavioural model.

// File: rtl/flagmask_alu_pkg.sv
package flagmask_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_XOR  = 5'd5,
    OP_OR   = 5'd6,
    OP_CMP  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_ADDW = 5'd10,
    OP_RLC  = 5'd11,
    OP_RRC  = 5'd12,
    OP_RLT  = 5'd13,
    OP_RRT  = 5'd14,
    OP_DADJ = 5'd15,
    OP_INV  = 5'd16,
    OP_SETC = 5'd17,
    OP_FLPC = 5'd18
  } alu_op_e;

  // Four architected flags, packed in flag-byte order (bit 7 down to bit 4).
  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag4_t;

  localparam int FLAG_NUM = 4;
  localparam int FLAG_LSB = 4;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_BYTE  = 2'd1,
    UNIT_WIDE  = 2'd2,
    UNIT_ACCMX = 2'd3
  } unit_e;

  // Which flags an operation is allowed to write.
  function automatic flag4_t update_mask(alu_op_e code);
    flag4_t m;
    unique case (code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_AND, OP_XOR, OP_OR, OP_CMP,
      OP_RLC, OP_RRC, OP_RLT, OP_RRT:  m = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
      OP_INC, OP_DEC:                  m = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
      OP_ADDW, OP_SETC, OP_FLPC:       m = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b1};
      OP_DADJ:                         m = '{z: 1'b1, n: 1'b0, h: 1'b1, c: 1'b1};
      OP_INV:                          m = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b0};
      default:                         m = '0;
    endcase
    return m;
  endfunction

  function automatic unit_e unit_of(alu_op_e code);
    unit_e u;
    unique case (code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND,
      OP_XOR, OP_OR, OP_CMP, OP_INC, OP_DEC:    u = UNIT_BYTE;
      OP_ADDW:                                  u = UNIT_WIDE;
      OP_RLC, OP_RRC, OP_RLT, OP_RRT,
      OP_DADJ, OP_INV, OP_SETC, OP_FLPC:        u = UNIT_ACCMX;
      default:                                  u = UNIT_NONE;
    endcase
    return u;
  endfunction

  function automatic logic writes_result(alu_op_e code);
    logic w;
    unique case (code)
      OP_CMP, OP_SETC, OP_FLPC: w = 1'b0;
      default:                  w = (unit_of(code) != UNIT_NONE);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/alu_byte_arith.sv
module alu_byte_arith
  import flagmask_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             code,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  input  logic                carry_in,
  output logic [DATA_W-1:0]   res,
  output flag4_t              raw
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low;
  logic [DATA_W-1:0] operand;
  logic              cy;

  always_comb begin
    cy      = 1'b0;
    operand = rhs;
    full    = '0;
    low     = '0;
    res     = '0;
    raw     = '0;
    unique case (code)
      OP_ADD, OP_ADC, OP_INC: begin
        if (code == OP_INC) operand = DATA_W'(1);
        cy   = (code == OP_ADC) && carry_in;
        full = {1'b0, lhs} + {1'b0, operand} + {{DATA_W{1'b0}}, cy};
        low  = {1'b0, lhs[NIB_W-1:0]} + {1'b0, operand[NIB_W-1:0]} + {{NIB_W{1'b0}}, cy};
        res  = full[DATA_W-1:0];
        raw.n = 1'b0;
        raw.h = low[NIB_W];
        raw.c = full[DATA_W];
      end
      OP_SUB, OP_SBC, OP_CMP, OP_DEC: begin
        if (code == OP_DEC) operand = DATA_W'(1);
        cy   = (code == OP_SBC) && carry_in;
        full = {1'b0, lhs} - {1'b0, operand} - {{DATA_W{1'b0}}, cy};
        low  = {1'b0, lhs[NIB_W-1:0]} - {1'b0, operand[NIB_W-1:0]} - {{NIB_W{1'b0}}, cy};
        res  = full[DATA_W-1:0];
        raw.n = 1'b1;
        raw.h = low[NIB_W];
        raw.c = full[DATA_W];
      end
      OP_AND: begin
        res   = lhs & rhs;
        raw.h = 1'b1;
      end
      OP_XOR: res = lhs ^ rhs;
      OP_OR:  res = lhs | rhs;
      default: res = '0;
    endcase
    raw.z = (res == '0);
  end

endmodule

// File: rtl/alu_wide_add.sv
module alu_wide_add
  import flagmask_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2*DATA_W-1:0] pair,
  input  logic [2*DATA_W-1:0] addend,
  output logic [2*DATA_W-1:0] sum,
  output flag4_t              raw
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam int HC_W   = WIDE_W - DATA_W / 2;

  logic [WIDE_W:0] full;
  logic [HC_W:0]   part;

  always_comb begin
    full  = {1'b0, pair} + {1'b0, addend};
    part  = {1'b0, pair[HC_W-1:0]} + {1'b0, addend[HC_W-1:0]};
    sum   = full[WIDE_W-1:0];
    raw.z = 1'b0;
    raw.n = 1'b0;
    raw.h = part[HC_W];
    raw.c = full[WIDE_W];
  end

endmodule

// File: rtl/alu_acc_misc.sv
module alu_acc_misc
  import flagmask_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           code,
  input  logic [DATA_W-1:0] acc,
  input  flag4_t            cur,
  output logic [DATA_W-1:0] res,
  output flag4_t            raw
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] HI_FIX  = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] LO_FIX  = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] HI_LIM  = DATA_W'(8'h99);
  localparam logic [NIB_W-1:0]  NIB_LIM = NIB_W'(9);

  logic [DATA_W-1:0] adj;
  logic              dcy;

  always_comb begin
    adj = '0;
    dcy = cur.c;
    if (!cur.n) begin
      if (cur.c || (acc > HI_LIM)) begin
        adj = adj | HI_FIX;
        dcy = 1'b1;
      end
      if (cur.h || (acc[NIB_W-1:0] > NIB_LIM)) adj = adj | LO_FIX;
    end else begin
      if (cur.c) adj = adj | HI_FIX;
      if (cur.h) adj = adj | LO_FIX;
    end
  end

  always_comb begin
    res = '0;
    raw = '0;
    unique case (code)
      OP_RLC: begin
        res   = {acc[DATA_W-2:0], acc[DATA_W-1]};
        raw.c = acc[DATA_W-1];
      end
      OP_RRC: begin
        res   = {acc[0], acc[DATA_W-1:1]};
        raw.c = acc[0];
      end
      OP_RLT: begin
        res   = {acc[DATA_W-2:0], cur.c};
        raw.c = acc[DATA_W-1];
      end
      OP_RRT: begin
        res   = {cur.c, acc[DATA_W-1:1]};
        raw.c = acc[0];
      end
      OP_DADJ: begin
        res   = cur.n ? (acc - adj) : (acc + adj);
        raw.z = (res == '0);
        raw.n = cur.n;
        raw.c = dcy;
      end
      OP_INV: begin
        res   = ~acc;
        raw.n = 1'b1;
        raw.h = 1'b1;
      end
      OP_SETC: raw.c = 1'b1;
      OP_FLPC: raw.c = ~cur.c;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import flagmask_alu_pkg::*;
(
  input  flag4_t mask,
  input  flag4_t fresh,
  input  flag4_t kept,
  output flag4_t merged
);
  logic [FLAG_NUM-1:0] m_v, f_v, k_v, o_v;

  assign m_v = mask;
  assign f_v = fresh;
  assign k_v = kept;

  for (genvar i = 0; i < FLAG_NUM; i++) begin : g_bit
    assign o_v[i] = m_v[i] ? f_v[i] : k_v[i];
  end

  assign merged = o_v;

endmodule

// File: rtl/flagmask_alu.sv
module flagmask_alu
  import flagmask_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [4:0]          op,
  input  logic [2*DATA_W-1:0] opa,
  input  logic [2*DATA_W-1:0] opb,
  input  logic [7:0]          flags_in,
  output logic                out_valid,
  output logic [2*DATA_W-1:0] result,
  output logic [7:0]          flags_out,
  output logic                res_we
);
  localparam int WIDE_W = 2 * DATA_W;

  alu_op_e code;
  flag4_t  cur;
  flag4_t  mask;
  unit_e   unit;

  assign code = alu_op_e'(op);
  assign cur  = flags_in[FLAG_LSB +: FLAG_NUM];
  assign mask = update_mask(code);
  assign unit = unit_of(code);

  logic [DATA_W-1:0] byte_res, misc_res;
  logic [WIDE_W-1:0] wide_res;
  flag4_t            byte_raw, wide_raw, misc_raw, sel_raw, new_flags;

  alu_byte_arith #(.DATA_W(DATA_W)) u_byte (
    .code     (code),
    .lhs      (opa[DATA_W-1:0]),
    .rhs      (opb[DATA_W-1:0]),
    .carry_in (cur.c),
    .res      (byte_res),
    .raw      (byte_raw)
  );

  alu_wide_add #(.DATA_W(DATA_W)) u_wide (
    .pair   (opa),
    .addend (opb),
    .sum    (wide_res),
    .raw    (wide_raw)
  );

  alu_acc_misc #(.DATA_W(DATA_W)) u_misc (
    .code (code),
    .acc  (opa[DATA_W-1:0]),
    .cur  (cur),
    .res  (misc_res),
    .raw  (misc_raw)
  );

  alu_flag_merge u_merge (
    .mask   (mask),
    .fresh  (sel_raw),
    .kept   (cur),
    .merged (new_flags)
  );

  // Next-state logic
  logic [WIDE_W-1:0] res_nx;
  logic              we_nx;
  logic [7:0]        flags_nx;

  always_comb begin
    unique case (unit)
      UNIT_BYTE:  begin sel_raw = byte_raw; res_nx = {{DATA_W{1'b0}}, byte_res}; end
      UNIT_WIDE:  begin sel_raw = wide_raw; res_nx = wide_res;                   end
      UNIT_ACCMX: begin sel_raw = misc_raw; res_nx = {{DATA_W{1'b0}}, misc_res}; end
      default:    begin sel_raw = '0;       res_nx = '0;                         end
    endcase
    we_nx = writes_result(code);
    if (!we_nx) res_nx = '0;
    flags_nx = {new_flags, {FLAG_LSB{1'b0}}};
  end

  // Output register, loaded only when an operation is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      res_we    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_nx;
        flags_out <= flags_nx;
        res_we    <= we_nx;
      end
    end
  end

endmodule

// File: rtl/flagmask_alu_checker.sv
module flagmask_alu_checker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [4:0]          op,
  input logic [2*DATA_W-1:0] opa,
  input logic [2*DATA_W-1:0] opb,
  input logic [7:0]          flags_in,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] result,
  input logic [7:0]          flags_out,
  input logic                res_we
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out) && $stable(res_we)));

  assert_low_nibble_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[3:0] == 4'h0);

  assert_compare_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd7) |=> (!res_we && result == '0));

  assert_incdec_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 5'd8 || op == 5'd9)) |=> (flags_out[4] == $past(flags_in[4])));

  assert_wide_keep_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd10) |=> (flags_out[7] == $past(flags_in[7]) && !flags_out[6]));

  assert_rotate_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 5'd11 && op <= 5'd14) |=> (flags_out[7:5] == 3'b000));

  assert_dadj_keep_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd15) |=> (flags_out[6] == $past(flags_in[6]) && !flags_out[5]));

  assert_invert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 5'd16) |=> (flags_out[6:5] == 2'b11 &&
                                   flags_out[7] == $past(flags_in[7]) &&
                                   flags_out[4] == $past(flags_in[4])));

  assert_carry_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 5'd17 || op == 5'd18)) |=> (!res_we && flags_out[6:5] == 2'b00 &&
                                                   flags_out[7] == $past(flags_in[7])));

  assert_unassigned_noop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 5'd19) |=> (!res_we && flags_out[7:4] == $past(flags_in[7:4])));

endmodule

bind flagmask_alu flagmask_alu_checker #(.DATA_W(DATA_W)) i_flagmask_alu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .opa       (opa),
  .opb       (opb),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out),
  .res_we    (res_we)
);

// File: tb/test_flagmask_alu.sv
`timescale 1ns/1ps
module test_flagmask_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op;
  logic [15:0] opa, opb;
  logic [7:0]  flags_in;
  logic        out_valid;
  logic [15:0] result;
  logic [7:0]  flags_out;
  logic        res_we;

  always #2.5 clk = ~clk;

  flagmask_alu i_flagmask_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .flags_out(flags_out), .res_we(res_we)
  );

  int n_checks = 0;
  int n_fails  = 0;

  logic        exp_v;
  logic [15:0] exp_res;
  logic [7:0]  exp_f;
  logic        exp_we;
  string       cur_req = "R1";

  function automatic string req_of(int code);
    if (code <= 3)  return "R3";
    if (code <= 6)  return "R4";
    if (code == 7)  return "R5";
    if (code <= 9)  return "R6";
    if (code == 10) return "R7";
    if (code <= 14) return "R8";
    if (code == 15) return "R9";
    if (code == 16) return "R10";
    if (code <= 18) return "R11";
    return "R12";
  endfunction

  // Behavioural reference: returns {we, flags, result}
  function automatic logic [24:0] model(int code, int a16, int b16, logic [7:0] f);
    int a, b, r, z, n, h, c, s, w;
    bit lo_fix;
    a = a16 & 255; b = b16 & 255;
    z = f[7]; n = f[6]; h = f[5]; c = f[4];
    r = 0; w = 1;
    case (code)
      0, 1: begin
        s = (code == 1) ? c : 0;
        h = ((a & 15) + (b & 15) + s) > 15;
        r = a + b + s; c = r > 255; r = r & 255; n = 0; z = (r == 0);
      end
      2, 3, 7: begin
        s = (code == 3) ? c : 0;
        h = (a & 15) < ((b & 15) + s);
        c = a < (b + s);
        r = (a - b - s) & 255; n = 1; z = (r == 0);
        if (code == 7) begin w = 0; r = 0; end
      end
      4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
      5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
      6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
      8: begin r = (a + 1) & 255; z = (r == 0); n = 0; h = (a & 15) == 15; end
      9: begin r = (a - 1) & 255; z = (r == 0); n = 1; h = (a & 15) == 0; end
      10: begin
        h = ((a16 & 4095) + (b16 & 4095)) > 4095;
        r = a16 + b16; c = r > 65535; r = r & 65535; n = 0;
      end
      11: begin c = a >> 7; r = ((a << 1) | c) & 255; z = 0; n = 0; h = 0; end
      12: begin s = a & 1; r = (a >> 1) | (s << 7); c = s; z = 0; n = 0; h = 0; end
      13: begin r = ((a << 1) | c) & 255; c = a >> 7; z = 0; n = 0; h = 0; end
      14: begin r = (a >> 1) | (c << 7); c = a & 1; z = 0; n = 0; h = 0; end
      15: begin
        lo_fix = (h != 0) || ((a & 15) > 9);
        r = a;
        if (n == 0) begin
          if (c != 0 || a > 153) begin r = r + 96; c = 1; end
          if (lo_fix) r = r + 6;
        end else begin
          if (c != 0) r = r - 96;
          if (h != 0) r = r - 6;
        end
        r = r & 255; z = (r == 0); h = 0;
      end
      16: begin r = (~a) & 255; n = 1; h = 1; end
      17: begin w = 0; c = 1; n = 0; h = 0; end
      18: begin w = 0; c = 1 - c; n = 0; h = 0; end
      default: begin w = 0; end
    endcase
    return {w[0], z[0], n[0], h[0], c[0], 4'h0, r[15:0]};
  endfunction

  task automatic compare();
    n_checks++;
    if (out_valid !== exp_v || result !== exp_res || flags_out !== exp_f || res_we !== exp_we) begin
      n_fails++;
      $display("FAIL %s: got v=%0b res=%h f=%h we=%0b, expected v=%0b res=%h f=%h we=%0b",
               cur_req, out_valid, result, flags_out, res_we, exp_v, exp_res, exp_f, exp_we);
    end
    n_checks++;
    if (flags_out[3:0] !== 4'h0) begin
      n_fails++;
      $display("FAIL R2: low nibble got %h expected 0", flags_out[3:0]);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register stage).
  task automatic step(input logic v, input int code, input int a, input int b, input logic [7:0] f);
    logic [24:0] m;
    in_valid = v; op = code[4:0]; opa = a[15:0]; opb = b[15:0]; flags_in = f;
    exp_v = v;
    if (v) begin
      m = model(code, a, b, f);
      exp_we = m[24]; exp_f = m[23:16]; exp_res = m[15:0];
      cur_req = req_of(code);
    end else cur_req = "R1";
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R1: watchdog expired, got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0; flags_in = '0;
    exp_v = 0; exp_res = '0; exp_f = '0; exp_we = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";   // reset state
    compare();
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 16'h003A, 16'h00C6, 8'h00);   // R3 add to zero, H and C
    step(1, 1, 16'h00E1, 16'h000F, 8'h1F);   // R3 add with carry, junk low nibble (R2)
    step(1, 2, 16'h003E, 16'h003E, 8'h00);   // R3 subtract to zero
    step(1, 3, 16'h0010, 16'h000F, 8'h10);   // R3 subtract with borrow
    step(1, 4, 16'h005A, 16'h00A5, 8'h00);   // R4 AND zero
    step(1, 5, 16'h00FF, 16'h000F, 8'hF0);   // R4 XOR
    step(1, 6, 16'h0000, 16'h0000, 8'hF0);   // R4 OR zero
    step(1, 7, 16'h0042, 16'h0042, 8'h00);   // R5 compare equal
    step(1, 7, 16'h0010, 16'h0020, 8'h00);   // R5 compare less
    step(1, 8, 16'h00FF, 16'h0000, 8'h10);   // R6 increment wraps, C kept 1
    step(1, 9, 16'h0010, 16'h0000, 8'h00);   // R6 decrement half-borrow, C kept 0
    step(1, 9, 16'h0001, 16'h0000, 8'h10);   // R6 decrement to zero
    step(1, 10, 16'h8A23, 16'h0605, 8'h80);  // R7 half-carry from bit 11, Z kept
    step(1, 10, 16'hFFFF, 16'h0001, 8'h40);  // R7 full carry, zero sum, Z kept 0
    step(1, 11, 16'h0085, 16'h0000, 8'h00);  // R8 rotate left circular
    step(1, 12, 16'h0000, 16'h0000, 8'hF0);  // R8 rotate zero, Z cleared
    step(1, 13, 16'h0080, 16'h0000, 8'h00);  // R8 through carry, result zero
    step(1, 14, 16'h0001, 16'h0000, 8'h10);  // R8 through carry right
    step(1, 15, 16'h007D, 16'h0000, 8'h00);  // R9 BCD add fix
    step(1, 15, 16'h009A, 16'h0000, 8'h00);  // R9 overflow to zero
    step(1, 15, 16'h0047, 16'h0000, 8'h60);  // R9 subtract fix
    step(1, 16, 16'h0035, 16'h0000, 8'h90);  // R10 complement
    step(1, 17, 16'h0000, 16'h0000, 8'hE0);  // R11 set carry
    step(1, 18, 16'h0000, 16'h0000, 8'hF0);  // R11 complement carry
    step(1, 19, 16'h1234, 16'h5678, 8'hB0);  // R12 unassigned
    step(1, 31, 16'hFFFF, 16'hFFFF, 8'h70);  // R12 unassigned
    step(0, 0, 16'h00FF, 16'h00FF, 8'h00);   // R1 idle holds
    step(0, 10, 16'hFFFF, 16'h0001, 8'hF0);  // R1 idle holds

    for (int k = 0; k < 4000; k++) begin
      step(($urandom_range(0, 9) != 0), $urandom_range(0, 31),
           $urandom_range(0, 65535), $urandom_range(0, 65535), 8'($urandom_range(0, 255)));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule